// File: doc/BRIEF.md
# Bridge Secondary Interrupt Status

This block gathers error and event conditions seen on the secondary side of a PCI-to-PCI bridge. It holds them in a seven-bit sticky status register and raises one interrupt request toward the local processor. The secondary bus interface supplies the inputs. Most are one-cycle event pulses covering parity failures, system-error detection and transaction abort outcomes. Two are levels: the parity-error-response enable and the software-owned secondary bus reset control bit.

Software reads the register through a simple port and clears bits by writing ones. A mask vector from a neighbouring control register can stop any source from setting its bit. The bit that records a released secondary bus reset comes from a small state machine that follows the control bit. It has three states. RT_IDLE means the control bit is low. RT_HELD means the bit is high. RT_RELEASE lasts one cycle and marks a 1-to-0 transition. The transitions are:
- IDLE→HELD when the bit is set.
- HELD→RELEASE when the bit drops.
- RELEASE→HELD when the bit rises again at once.
- RELEASE→IDLE otherwise.

Top module: `bridge_sec_irq_status`

## Requirements
- R1: After reset every status bit reads 0 and `irq` is 0. Read data bits 31:7 always read 0.
- R2: Writing 1 to a bit position with `reg_wr` high clears that status bit on the next edge. A 0 in that position leaves the bit unchanged.
- R3: Bit 6 sets two edges after `sec_rst_ctl` is first sampled low following a sample where it was high. Setting the control bit, or holding it at either level, does not set bit 6.
- R4: Bit 5 sets on the edge after any of `ev_wr_perr_tgt`, `ev_rd_perr_mst` or `ev_addr_perr`, whatever the value of `perr_resp_en`.
- R5: Bit 4 sets on the edge after `ev_serr`.
- R6: Bit 3 sets on the edge after `ev_mst_abort`. Bit 2 sets on the edge after `ev_tgt_abort_rcvd`.
- R7: Bit 1 sets on the edge after `ev_tgt_abort_sig`.
- R8: Bit 0 sets only when `ev_perr_seen`, `ev_perr_as_mst` and `perr_resp_en` are all high in the same cycle. Any two of them alone leave it clear.
- R9: `src_mask[i]=1` stops bit i from setting. A mask bit never clears a bit that is already set.
- R10: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends set.
- R11: `irq` is high exactly while any status bit is set. It stays high across idle cycles until every set bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_rst_ctl | input | 1 | Software secondary bus reset control bit (level) |
| perr_resp_en | input | 1 | Parity-error-response enable (level) |
| ev_wr_perr_tgt | input | 1 | Write-data parity error as secondary target |
| ev_rd_perr_mst | input | 1 | Read-data parity error as secondary master |
| ev_addr_perr | input | 1 | Address parity error on secondary bus |
| ev_serr | input | 1 | Secondary system error detected |
| ev_mst_abort | input | 1 | Secondary-initiated transaction ended in master-abort |
| ev_tgt_abort_rcvd | input | 1 | Secondary-initiated transaction ended in target-abort |
| ev_tgt_abort_sig | input | 1 | Secondary target terminated with target-abort |
| ev_perr_seen | input | 1 | Parity-error signal driven or observed asserted |
| ev_perr_as_mst | input | 1 | Bridge was bus master for the failing operation |
| src_mask | input | 7 | Per-bit set suppression, 1 = suppress |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data, ones clear matching bits |
| reg_rdata | output | 32 | Status read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these behaviours on every cycle:
- A set event leaves its bit set even when a clear hits it in the same cycle.
- A bit holds unless a one is written to its position.
- A clear with no competing event empties the bit.
- The release state machine emits its pulse after a high-to-low sample and never after a high sample.
- The master parity bit never sets without the response enable.
- The interrupt holds while no write arrives.

Only the bench scenarios can show end-to-end timing against the ports. These include the two-edge latency of the reset-release bit, the exact bit each event lands in, the three-way qualification of bit 0, and the interplay of masks, clears and events under random traffic.

// File: rtl/sbis_pkg.sv
package sbis_pkg;
    localparam int STAT_W = 7;

    localparam int B_MPE  = 0;
    localparam int B_TAS  = 1;
    localparam int B_TAR  = 2;
    localparam int B_MAB  = 3;
    localparam int B_SERR = 4;
    localparam int B_DPE  = 5;
    localparam int B_RST  = 6;

    typedef enum logic [1:0] {
        RT_IDLE    = 2'd0,
        RT_HELD    = 2'd1,
        RT_RELEASE = 2'd2
    } rt_state_t;
endpackage

// File: rtl/sbis_rst_tracker.sv
module sbis_rst_tracker
    import sbis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl,
    output logic rel_pulse
);
    rt_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_IDLE:    state_d = ctl ? RT_HELD : RT_IDLE;
            RT_HELD:    state_d = ctl ? RT_HELD : RT_RELEASE;
            RT_RELEASE: state_d = ctl ? RT_HELD : RT_IDLE;
            default:    state_d = RT_IDLE;
        endcase
    end

    always_comb begin
        rel_pulse = (state_q == RT_RELEASE);
    end

    AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RT_HELD && !ctl) |=> rel_pulse); // R3
    AST_NO_PULSE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl |=> !rel_pulse); // R3
endmodule

// File: rtl/sbis_event_qual.sv
module sbis_event_qual
    import sbis_pkg::*;
(
    input  logic              rel_pulse,
    input  logic              perr_resp_en,
    input  logic              ev_wr_perr_tgt,
    input  logic              ev_rd_perr_mst,
    input  logic              ev_addr_perr,
    input  logic              ev_serr,
    input  logic              ev_mst_abort,
    input  logic              ev_tgt_abort_rcvd,
    input  logic              ev_tgt_abort_sig,
    input  logic              ev_perr_seen,
    input  logic              ev_perr_as_mst,
    input  logic [STAT_W-1:0] src_mask,
    output logic [STAT_W-1:0] set_vec
);
    logic [STAT_W-1:0] raw;

    always_comb begin
        raw         = '0;
        raw[B_RST]  = rel_pulse;
        raw[B_DPE]  = ev_wr_perr_tgt | ev_rd_perr_mst | ev_addr_perr;
        raw[B_SERR] = ev_serr;
        raw[B_MAB]  = ev_mst_abort;
        raw[B_TAR]  = ev_tgt_abort_rcvd;
        raw[B_TAS]  = ev_tgt_abort_sig;
        raw[B_MPE]  = ev_perr_seen & ev_perr_as_mst & perr_resp_en;
        set_vec     = raw & ~src_mask;
    end
endmodule

// File: rtl/sbis_status_reg.sv
module sbis_status_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          stat[i] <= 1'b0;
            else if (set_vec[i]) stat[i] <= 1'b1;
            else if (clr_vec[i]) stat[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> stat[i]); // R10
        AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !clr_vec[i]) |=> stat[i]); // R2
        AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !stat[i]); // R2
    end
endmodule

// File: rtl/bridge_sec_irq_status.sv
module bridge_sec_irq_status
    import sbis_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_rst_ctl,
    input  logic              perr_resp_en,
    input  logic              ev_wr_perr_tgt,
    input  logic              ev_rd_perr_mst,
    input  logic              ev_addr_perr,
    input  logic              ev_serr,
    input  logic              ev_mst_abort,
    input  logic              ev_tgt_abort_rcvd,
    input  logic              ev_tgt_abort_sig,
    input  logic              ev_perr_seen,
    input  logic              ev_perr_as_mst,
    input  logic [STAT_W-1:0] src_mask,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int RSVD_W = DATA_W - STAT_W;

    logic              rel_pulse;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] stat;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:STAT_W];
    assign clr_vec         = {STAT_W{reg_wr}} & reg_wdata[STAT_W-1:0];

    sbis_rst_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (sec_rst_ctl),
        .rel_pulse (rel_pulse)
    );

    sbis_event_qual u_qual (
        .rel_pulse         (rel_pulse),
        .perr_resp_en      (perr_resp_en),
        .ev_wr_perr_tgt    (ev_wr_perr_tgt),
        .ev_rd_perr_mst    (ev_rd_perr_mst),
        .ev_addr_perr      (ev_addr_perr),
        .ev_serr           (ev_serr),
        .ev_mst_abort      (ev_mst_abort),
        .ev_tgt_abort_rcvd (ev_tgt_abort_rcvd),
        .ev_tgt_abort_sig  (ev_tgt_abort_sig),
        .ev_perr_seen      (ev_perr_seen),
        .ev_perr_as_mst    (ev_perr_as_mst),
        .src_mask          (src_mask),
        .set_vec           (set_vec)
    );

    sbis_status_reg #(.W(STAT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat    (stat)
    );

    always_comb begin
        reg_rdata = {{RSVD_W{1'b0}}, stat};
        irq       = |stat;
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> irq); // R11
    AST_MPE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_resp_en && !reg_rdata[B_MPE]) |=> !reg_rdata[B_MPE]); // R8
    AST_DPE_NO_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr_perr && !src_mask[B_DPE]) |=> reg_rdata[B_DPE]); // R4
endmodule

// File: tb/tb_bridge_sec_irq_status.sv
`timescale 1ns/1ps
module tb_bridge_sec_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_rst_ctl = 1'b0, perr_resp_en = 1'b0;
    logic        ev_wr_perr_tgt = 1'b0, ev_rd_perr_mst = 1'b0, ev_addr_perr = 1'b0;
    logic        ev_serr = 1'b0, ev_mst_abort = 1'b0, ev_tgt_abort_rcvd = 1'b0;
    logic        ev_tgt_abort_sig = 1'b0, ev_perr_seen = 1'b0, ev_perr_as_mst = 1'b0;
    logic [6:0]  src_mask = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    logic [6:0]  m_stat = '0;
    logic        m_held = 1'b0, m_rel = 1'b0;
    int          n_vec = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bridge_sec_irq_status dut (.*);

    function automatic logic [6:0] exp_set();
        logic [6:0] r;
        r[6] = m_rel;
        r[5] = ev_wr_perr_tgt | ev_rd_perr_mst | ev_addr_perr;
        r[4] = ev_serr;
        r[3] = ev_mst_abort;
        r[2] = ev_tgt_abort_rcvd;
        r[1] = ev_tgt_abort_sig;
        r[0] = ev_perr_seen & ev_perr_as_mst & perr_resp_en;
        return r & ~src_mask;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic quiet();
        ev_wr_perr_tgt = 0; ev_rd_perr_mst = 0; ev_addr_perr = 0; ev_serr = 0;
        ev_mst_abort = 0; ev_tgt_abort_rcvd = 0; ev_tgt_abort_sig = 0;
        ev_perr_seen = 0; ev_perr_as_mst = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic step(string tag);
        logic [6:0] clr, nxt;
        logic       n_rel, n_held;
        clr    = reg_wr ? reg_wdata[6:0] : 7'd0;
        nxt    = exp_set() | (m_stat & ~clr);
        n_rel  = m_held & ~sec_rst_ctl;
        n_held = sec_rst_ctl;
        @(posedge clk); #1;
        m_stat = nxt; m_rel = n_rel; m_held = n_held;
        check(tag, reg_rdata, {25'd0, m_stat});
        check(tag, {31'd0, irq}, {31'd0, |m_stat});
        quiet();
    endtask

    task automatic clear_all();
        reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
        step("R2");
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1", reg_rdata, 32'd0);
        check("R1", {31'd0, irq}, 32'd0);
        rst_n = 1;

        ev_serr = 1; step("R5");
        check("R5", reg_rdata, 32'h10);
        step("R11");
        reg_wr = 1; reg_wdata = 32'h0000_0000; step("R2");
        check("R2", reg_rdata, 32'h10);
        clear_all();

        ev_wr_perr_tgt = 1; step("R4"); clear_all();
        ev_rd_perr_mst = 1; step("R4"); clear_all();
        ev_addr_perr = 1; step("R4");
        check("R4", reg_rdata, 32'h20); clear_all();

        ev_mst_abort = 1; step("R6"); check("R6", reg_rdata, 32'h08);
        ev_tgt_abort_rcvd = 1; step("R6"); check("R6", reg_rdata, 32'h0C);
        ev_tgt_abort_sig = 1; step("R7"); check("R7", reg_rdata, 32'h0E);
        reg_wr = 1; reg_wdata = 32'h04; step("R2"); check("R2", reg_rdata, 32'h0A);
        clear_all();

        ev_perr_seen = 1; ev_perr_as_mst = 1; step("R8");
        check("R8", reg_rdata, 32'h00);
        perr_resp_en = 1;
        ev_perr_seen = 1; step("R8"); check("R8", reg_rdata, 32'h00);
        ev_perr_as_mst = 1; step("R8"); check("R8", reg_rdata, 32'h00);
        ev_perr_seen = 1; ev_perr_as_mst = 1; step("R8");
        check("R8", reg_rdata, 32'h01);
        clear_all(); perr_resp_en = 0;

        sec_rst_ctl = 1; step("R3"); check("R3", reg_rdata, 32'h00);
        step("R3"); check("R3", reg_rdata, 32'h00);
        sec_rst_ctl = 0; step("R3"); check("R3", reg_rdata, 32'h00);
        step("R3"); check("R3", reg_rdata, 32'h40);
        clear_all();

        src_mask = 7'h10; ev_serr = 1; step("R9"); check("R9", reg_rdata, 32'h00);
        src_mask = 7'h00; ev_serr = 1; step("R9");
        src_mask = 7'h10; step("R9"); check("R9", reg_rdata, 32'h10);
        src_mask = 7'h00;

        ev_serr = 1; reg_wr = 1; reg_wdata = 32'h10; step("R10");
        check("R10", reg_rdata, 32'h10);
        repeat (3) step("R11");
        check("R11", {31'd0, irq}, 32'd1);
        clear_all();
        check("R11", {31'd0, irq}, 32'd0);

        for (int k = 0; k < 3000; k++) begin
            ev_wr_perr_tgt    = ($urandom % 10) == 0;
            ev_rd_perr_mst    = ($urandom % 10) == 0;
            ev_addr_perr      = ($urandom % 10) == 0;
            ev_serr           = ($urandom % 10) == 0;
            ev_mst_abort      = ($urandom % 10) == 0;
            ev_tgt_abort_rcvd = ($urandom % 10) == 0;
            ev_tgt_abort_sig  = ($urandom % 10) == 0;
            ev_perr_seen      = ($urandom % 4) == 0;
            ev_perr_as_mst    = ($urandom % 2) == 0;
            if (($urandom % 16) == 0) perr_resp_en = ~perr_resp_en;
            if (($urandom % 6) == 0)  sec_rst_ctl  = ~sec_rst_ctl;
            if (($urandom % 20) == 0)
                src_mask = (($urandom % 3) == 0) ? 7'(($urandom)) : 7'd0;
            reg_wr    = ($urandom % 4) == 0;
            reg_wdata = $urandom;
            step("R2/R11 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule